// File: doc/BRIEF.md
# Streaming CRC Engine with Input Reordering and Post-Processing

This block keeps a running CRC over a stream of 32-bit data writes. There is no start or stop command: every data strobe folds the written word (or only its low byte) into the running value, and the new value can be read one cycle later. Before the data reaches the CRC logic, it passes through an input stage. This stage can rearrange the four byte lanes in one of four orders and can mirror the bits inside every byte. That lets a host feed the engine from memory of either byte order, and with either bit convention.

The configuration is captured from a set of control inputs on a configuration strobe. It selects the following:
- byte or word data size
- lane order
- per-byte bit mirroring
- a 32-bit or 16-bit polynomial
- two output options
- an optional initialisation to all zeros or all ones

The running value doubles as a context register. Software may load any seed into it, read it back, and later restore it to resume a suspended stream. A second output presents the same value after optional bit mirroring across the active CRC width and optional inversion. The raw value is always available unchanged.

Top module: `crc_stream_engine`

## Requirements
- R1: In word mode (byte-mode bit 0), each cycle with `din_wr` high advances the state by all 32 bits of the reordered word, most significant bit first. The result appears on `crc_raw` after the next rising edge. A cycle with no `seed_wr`, no `din_wr` and no initialising `cfg_wr` leaves the state unchanged.
- R2: With the narrow bit 0 the engine computes an unreflected CRC-32 with polynomial 0x04C11DB7. With the narrow bit 1 it computes CRC-16 with polynomial 0x1021 on the low 16 state bits, and `crc_raw[31:16]` reads zero. From an all-ones start, the ASCII string "123456789" gives 0x0376E6E7 and 0x000029B1 respectively.
- R3: In byte mode, each data write advances the state by 8 bits, taken from `din_data[7:0]` only. Bits 31:8 and the lane order setting have no effect on the result.
- R4: Lane order, with B0 = `din_data[7:0]` and B3 = `din_data[31:24]`, listed from the first byte processed to the last. Code 0 gives B3,B2,B1,B0. Code 1 gives B2,B3,B0,B1. Code 2 gives B1,B0,B3,B2. Code 3 gives B0,B1,B2,B3.
- R5: With bit mirroring on, each byte is bit-reversed after the lane reordering. In byte mode the low byte is bit-reversed.
- R6: Initialisation code 2'b01 loads all zeros into the state and codes 2'b10 and 2'b11 load all ones. This happens on the edge that captures `cfg_wr`. Code 2'b00 leaves the state untouched.
- R7: `seed_wr` loads `seed_data` into the 32-bit state, and `crc_raw` shows it on the next cycle (zero-extended from 16 bits in narrow mode).
- R8: In a single cycle, `seed_wr` takes priority over an initialising `cfg_wr`, which takes priority over `din_wr`. The data write in such a cycle is dropped.
- R9: `crc_post` equals `crc_raw`, bit-reversed across the active width (32 or 16 bits) when output mirroring is on, and then inverted across the active width when output inversion is on. The bits above the active width stay zero.
- R10: After reset the state is zero and every configuration field is zero. A data write in the same cycle as `cfg_wr` is processed with the previous configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Capture the configuration inputs |
| cfg_byte_mode | input | 1 | 1: byte-sized data, 0: 32-bit data |
| cfg_order | input | 2 | Byte lane order code |
| cfg_bit_rev | input | 1 | Mirror bits inside each input byte |
| cfg_narrow | input | 1 | 1: CRC-16, 0: CRC-32 |
| cfg_out_rev | input | 1 | Mirror the post-processed result |
| cfg_out_inv | input | 1 | Invert the post-processed result |
| cfg_init | input | 2 | Initialisation code applied with `cfg_wr` |
| seed_wr | input | 1 | Load the state from `seed_data` |
| seed_data | input | 32 | Seed or saved context |
| din_wr | input | 1 | Data write strobe |
| din_data | input | 32 | Data word |
| crc_raw | output | 32 | Running CRC value |
| crc_post | output | 32 | Post-processed CRC value |

## Verification
The bench concentrates on the corner cases below. For each one, it names the fault a wrong design would show.

- **Known check strings.** The bench runs the standard check string through both polynomials, mixing word and byte writes mid-stream, and compares against the published check values. A swapped lane order or processing the least significant bit first changes these values.
- **Lane orders and bit mirroring.** Each lane order and the bit-mirroring option is fed a word arranged so that a correct design lands on the same CRC as the plain word. A design that mislabels a code, or mirrors before reordering, diverges.
- **Byte mode.** Byte mode is driven with junk in the upper bits and a non-zero order code. A design that let those bits or the order code in produces a different value.
- **Coincident strobes.** Simultaneous seed, initialisation and data strobes expose a wrong priority.
- **Configuration timing.** A data write alongside a configuration change shows whether the new settings leak into the same cycle.
- **Narrow post-processing.** Post-processing in narrow mode catches mirroring across the wrong width.

// File: rtl/crc_stream_pkg.sv
package crc_stream_pkg;

   typedef enum logic [1:0] {
      ORD_PASS       = 2'd0,
      ORD_HALF_BYTES = 2'd1,
      ORD_HALVES     = 2'd2,
      ORD_FULL       = 2'd3
   } lane_order_e;

   localparam logic [1:0] INIT_KEEP = 2'b00;
   localparam logic [1:0] INIT_ZERO = 2'b01;

   typedef struct packed {
      logic        byte_mode;
      lane_order_e order;
      logic        bit_rev;
      logic        narrow;
      logic        out_rev;
      logic        out_inv;
   } crc_cfg_t;

endpackage

// File: rtl/crc_in_stage.sv
module crc_in_stage
   import crc_stream_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int LANES  = 4
) (
   input  logic [LANE_W*LANES-1:0] word_i,
   input  lane_order_e             order_i,
   input  logic                    bit_rev_i,
   output logic [LANE_W*LANES-1:0] word_o,
   output logic [LANE_W-1:0]       byte_o
);
   localparam int WORD_W = LANE_W * LANES;

   if (LANES != 4) begin : g_bad_lanes
      $error("crc_in_stage needs exactly four lanes");
   end

   logic [LANE_W-1:0] lane_in  [LANES];
   logic [LANE_W-1:0] lane_ord [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_split
      assign lane_in[g] = word_i[g*LANE_W +: LANE_W];
   end

   // lane_ord[3] is processed first, lane_ord[0] last
   always_comb begin
      unique case (order_i)
         ORD_HALF_BYTES: begin
            lane_ord[3] = lane_in[2]; lane_ord[2] = lane_in[3];
            lane_ord[1] = lane_in[0]; lane_ord[0] = lane_in[1];
         end
         ORD_HALVES: begin
            lane_ord[3] = lane_in[1]; lane_ord[2] = lane_in[0];
            lane_ord[1] = lane_in[3]; lane_ord[0] = lane_in[2];
         end
         ORD_FULL: begin
            lane_ord[3] = lane_in[0]; lane_ord[2] = lane_in[1];
            lane_ord[1] = lane_in[2]; lane_ord[0] = lane_in[3];
         end
         default: begin
            for (int k = 0; k < LANES; k++) lane_ord[k] = lane_in[k];
         end
      endcase
   end

   logic [WORD_W-1:0] mirrored;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      for (genvar b = 0; b < LANE_W; b++) begin : g_bit
         assign mirrored[g*LANE_W + b] = lane_ord[g][LANE_W-1-b];
      end
   end

   logic [LANE_W-1:0] low_mirror;
   for (genvar b = 0; b < LANE_W; b++) begin : g_low
      assign low_mirror[b] = word_i[LANE_W-1-b];
   end

   always_comb begin
      for (int k = 0; k < LANES; k++) word_o[k*LANE_W +: LANE_W] = lane_ord[k];
      if (bit_rev_i) word_o = mirrored;
   end

   assign byte_o = bit_rev_i ? low_mirror : word_i[LANE_W-1:0];

endmodule

// File: rtl/crc_step.sv
module crc_step #(
   parameter int           W     = 32,
   parameter logic [W-1:0] POLY  = '1,
   parameter int           NBITS = 32
) (
   input  logic [W-1:0]     state_i,
   input  logic [NBITS-1:0] data_i,
   output logic [W-1:0]     next_o
);
   if (W < 2 || NBITS < 1) begin : g_bad_size
      $error("crc_step width or bit count out of range");
   end

   always_comb begin
      logic [W-1:0] acc;
      logic         fb;
      acc = state_i;
      for (int i = NBITS - 1; i >= 0; i--) begin
         fb  = acc[W-1] ^ data_i[i];
         acc = {acc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end
      next_o = acc;
   end

endmodule

// File: rtl/crc_lane.sv
module crc_lane #(
   parameter int           W      = 32,
   parameter logic [W-1:0] POLY   = '1,
   parameter int           WORD_W = 32,
   parameter int           BYTE_W = 8
) (
   input  logic [W-1:0]      state_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              byte_mode_i,
   output logic [W-1:0]      next_o
);
   logic [W-1:0] next_word, next_byte;

   crc_step #(.W(W), .POLY(POLY), .NBITS(WORD_W)) u_word (
      .state_i (state_i),
      .data_i  (word_i),
      .next_o  (next_word)
   );

   crc_step #(.W(W), .POLY(POLY), .NBITS(BYTE_W)) u_byte (
      .state_i (state_i),
      .data_i  (byte_i),
      .next_o  (next_byte)
   );

   assign next_o = byte_mode_i ? next_byte : next_word;

endmodule

// File: rtl/crc_out_stage.sv
module crc_out_stage #(
   parameter int WIDE_W   = 32,
   parameter int NARROW_W = 16
) (
   input  logic [WIDE_W-1:0] state_i,
   input  logic              narrow_i,
   input  logic              out_rev_i,
   input  logic              out_inv_i,
   output logic [WIDE_W-1:0] raw_o,
   output logic [WIDE_W-1:0] post_o
);
   localparam int PAD_W = WIDE_W - NARROW_W;

   logic [WIDE_W-1:0] rev_wide, rev_narrow, mask, mirrored;

   always_comb begin
      rev_wide   = '0;
      rev_narrow = '0;
      for (int i = 0; i < WIDE_W; i++)   rev_wide[i]   = state_i[WIDE_W-1-i];
      for (int i = 0; i < NARROW_W; i++) rev_narrow[i] = state_i[NARROW_W-1-i];
   end

   always_comb begin
      if (narrow_i) begin
         raw_o    = {{PAD_W{1'b0}}, state_i[NARROW_W-1:0]};
         mask     = {{PAD_W{1'b0}}, {NARROW_W{1'b1}}};
         mirrored = rev_narrow;
      end else begin
         raw_o    = state_i;
         mask     = '1;
         mirrored = rev_wide;
      end
      post_o = (out_rev_i ? mirrored : raw_o) ^ (out_inv_i ? mask : '0);
   end

endmodule

// File: rtl/crc_stream_engine.sv
module crc_stream_engine
   import crc_stream_pkg::*;
#(
   parameter int                  DATA_W      = 32,
   parameter int                  BYTE_W      = 8,
   parameter logic [DATA_W-1:0]   POLY_WIDE   = 32'h04C1_1DB7,
   parameter int                  NARROW_W    = 16,
   parameter logic [NARROW_W-1:0] POLY_NARROW = 16'h1021
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_byte_mode,
   input  logic [1:0]        cfg_order,
   input  logic              cfg_bit_rev,
   input  logic              cfg_narrow,
   input  logic              cfg_out_rev,
   input  logic              cfg_out_inv,
   input  logic [1:0]        cfg_init,
   input  logic              seed_wr,
   input  logic [DATA_W-1:0] seed_data,
   input  logic              din_wr,
   input  logic [DATA_W-1:0] din_data,
   output logic [DATA_W-1:0] crc_raw,
   output logic [DATA_W-1:0] crc_post
);
   localparam int LANES  = DATA_W / BYTE_W;
   localparam int WIDE_W = DATA_W;
   localparam int PAD_W  = WIDE_W - NARROW_W;

   if (LANES * BYTE_W != DATA_W || LANES != 4) begin : g_bad_data_w
      $error("data width must be four byte lanes");
   end
   if (NARROW_W < BYTE_W || NARROW_W >= WIDE_W) begin : g_bad_narrow
      $error("narrow CRC width out of range");
   end

   crc_cfg_t          cfg_q;
   logic [WIDE_W-1:0] state_q, state_d;
   logic [DATA_W-1:0] word_ord;
   logic [BYTE_W-1:0] byte_sel;
   logic [WIDE_W-1:0] next_wide;
   logic [NARROW_W-1:0] next_narrow;
   logic              init_load;

   crc_in_stage #(.LANE_W(BYTE_W), .LANES(LANES)) u_in (
      .word_i    (din_data),
      .order_i   (cfg_q.order),
      .bit_rev_i (cfg_q.bit_rev),
      .word_o    (word_ord),
      .byte_o    (byte_sel)
   );

   for (genvar v = 0; v < 2; v++) begin : g_variant
      if (v == 0) begin : g_wide
         crc_lane #(.W(WIDE_W), .POLY(POLY_WIDE), .WORD_W(DATA_W), .BYTE_W(BYTE_W)) u_lane (
            .state_i     (state_q),
            .word_i      (word_ord),
            .byte_i      (byte_sel),
            .byte_mode_i (cfg_q.byte_mode),
            .next_o      (next_wide)
         );
      end else begin : g_narrow
         crc_lane #(.W(NARROW_W), .POLY(POLY_NARROW), .WORD_W(DATA_W), .BYTE_W(BYTE_W)) u_lane (
            .state_i     (state_q[NARROW_W-1:0]),
            .word_i      (word_ord),
            .byte_i      (byte_sel),
            .byte_mode_i (cfg_q.byte_mode),
            .next_o      (next_narrow)
         );
      end
   end

   assign init_load = cfg_wr && (cfg_init != INIT_KEEP);

   always_comb begin
      state_d = state_q;
      if (seed_wr)
         state_d = seed_data;
      else if (init_load)
         state_d = (cfg_init == INIT_ZERO) ? '0 : '1;
      else if (din_wr)
         state_d = cfg_q.narrow ? {{PAD_W{1'b0}}, next_narrow} : next_wide;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= '0;
         cfg_q   <= '0;
      end else begin
         state_q <= state_d;
         if (cfg_wr) begin
            cfg_q.byte_mode <= cfg_byte_mode;
            cfg_q.order     <= lane_order_e'(cfg_order);
            cfg_q.bit_rev   <= cfg_bit_rev;
            cfg_q.narrow    <= cfg_narrow;
            cfg_q.out_rev   <= cfg_out_rev;
            cfg_q.out_inv   <= cfg_out_inv;
         end
      end
   end

   crc_out_stage #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_out (
      .state_i   (state_q),
      .narrow_i  (cfg_q.narrow),
      .out_rev_i (cfg_q.out_rev),
      .out_inv_i (cfg_q.out_inv),
      .raw_o     (crc_raw),
      .post_o    (crc_post)
   );

endmodule

// File: rtl/crc_stream_checker.sv
module crc_stream_checker
   import crc_stream_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        cfg_wr,
   input logic [1:0]  cfg_init,
   input logic        seed_wr,
   input logic [31:0] seed_data,
   input logic        din_wr,
   input logic [31:0] state_q,
   input crc_cfg_t    cfg_q,
   input logic [31:0] crc_raw,
   input logic [31:0] crc_post
);

   p_seed_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      seed_wr |=> state_q == $past(seed_data));

   p_init_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_init == 2'b01 && !seed_wr) |=> state_q == 32'h0);

   p_init_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_init[1] && !seed_wr) |=> state_q == 32'hFFFF_FFFF);

   p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!seed_wr && !din_wr && !(cfg_wr && cfg_init != 2'b00)) |=> $stable(state_q));

   p_narrow_zext_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q.narrow |-> crc_raw[31:16] == 16'h0);

   p_post_plain_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_q.out_rev && !cfg_q.out_inv) |-> crc_post == crc_raw);

   p_post_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q.narrow |-> crc_post[31:16] == 16'h0);

endmodule

bind crc_stream_engine crc_stream_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_wr    (cfg_wr),
   .cfg_init  (cfg_init),
   .seed_wr   (seed_wr),
   .seed_data (seed_data),
   .din_wr    (din_wr),
   .state_q   (state_q),
   .cfg_q     (cfg_q),
   .crc_raw   (crc_raw),
   .crc_post  (crc_post)
);

// File: tb/tb_crc_stream_engine.sv
module tb_crc_stream_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic        cfg_byte_mode = 1'b0;
   logic [1:0]  cfg_order = 2'd0;
   logic        cfg_bit_rev = 1'b0;
   logic        cfg_narrow = 1'b0;
   logic        cfg_out_rev = 1'b0;
   logic        cfg_out_inv = 1'b0;
   logic [1:0]  cfg_init = 2'b00;
   logic        seed_wr = 1'b0;
   logic [31:0] seed_data = '0;
   logic        din_wr = 1'b0;
   logic [31:0] din_data = '0;
   logic [31:0] crc_raw, crc_post;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   crc_stream_engine dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_byte_mode(cfg_byte_mode),
      .cfg_order(cfg_order), .cfg_bit_rev(cfg_bit_rev), .cfg_narrow(cfg_narrow),
      .cfg_out_rev(cfg_out_rev), .cfg_out_inv(cfg_out_inv), .cfg_init(cfg_init),
      .seed_wr(seed_wr), .seed_data(seed_data), .din_wr(din_wr), .din_data(din_data),
      .crc_raw(crc_raw), .crc_post(crc_post)
   );

   // bit-serial reference built from R1, R2
   function automatic logic [31:0] ref_step(input logic [31:0] s, input logic [31:0] d,
                                            input int nb, input bit n16);
      logic fb;
      for (int i = nb - 1; i >= 0; i--) begin
         if (n16) begin
            fb = s[15] ^ d[i];
            s[15:0] = {s[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0);
         end else begin
            fb = s[31] ^ d[i];
            s = {s[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
         end
      end
      if (n16) s[31:16] = '0;
      return s;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic cycle(input logic sw, input logic [31:0] sd, input logic cw,
                        input logic [1:0] ini, input logic dw, input logic [31:0] dd);
      @(negedge clk);
      seed_wr = sw; seed_data = sd; cfg_wr = cw; cfg_init = ini;
      din_wr = dw; din_data = dd;
      @(negedge clk);
      seed_wr = 0; cfg_wr = 0; din_wr = 0; cfg_init = 2'b00;
   endtask

   task automatic set_cfg(input logic bm, input logic [1:0] ord, input logic br,
                          input logic nw, input logic orv, input logic oiv, input logic [1:0] ini);
      cfg_byte_mode = bm; cfg_order = ord; cfg_bit_rev = br; cfg_narrow = nw;
      cfg_out_rev = orv; cfg_out_inv = oiv;
      cycle(0, 0, 1, ini, 0, 0);
   endtask

   task automatic wr(input logic [31:0] d);
      cycle(0, 0, 0, 2'b00, 1, d);
   endtask

   task automatic t_reset();
      check("R10 reset raw", crc_raw, 32'h0);
      check("R10 reset post", crc_post, 32'h0);
   endtask

   task automatic t_crc32_string();
      set_cfg(0, 0, 0, 0, 0, 0, 2'b10);
      check("R6 init ones", crc_raw, 32'hFFFF_FFFF);
      wr(32'h3132_3334);
      check("R1 first word", crc_raw, ref_step(32'hFFFF_FFFF, 32'h3132_3334, 32, 0));
      wr(32'h3536_3738);
      set_cfg(1, 0, 0, 0, 0, 0, 2'b00);
      wr(32'h0000_0039);
      check("R2 crc32 check value", crc_raw, 32'h0376_E6E7);
      check("R9 post plain", crc_post, 32'h0376_E6E7);
   endtask

   task automatic t_crc16_string();
      set_cfg(1, 0, 0, 1, 0, 0, 2'b11);
      for (int i = 0; i < 9; i++) wr(32'h31 + i);
      check("R2 crc16 check value", crc_raw, 32'h0000_29B1);
      set_cfg(0, 0, 0, 1, 0, 0, 2'b10);
      wr(32'h3132_3334);
      check("R2 crc16 word", crc_raw, ref_step(32'hFFFF_FFFF, 32'h3132_3334, 32, 1));
   endtask

   task automatic t_orders();
      logic [31:0] words [4] = '{32'h3132_3334, 32'h3231_3433, 32'h3334_3132, 32'h3433_3231};
      for (int m = 0; m < 4; m++) begin
         set_cfg(0, 2'(m), 0, 0, 0, 0, 2'b10);
         wr(words[m]);
         check($sformatf("R4 order %0d", m), crc_raw,
               ref_step(32'hFFFF_FFFF, 32'h3132_3334, 32, 0));
      end
   endtask

   task automatic t_bitrev();
      set_cfg(0, 0, 1, 0, 0, 0, 2'b10);
      wr(32'h8C4C_CC2C);
      check("R5 word mirror", crc_raw, ref_step(32'hFFFF_FFFF, 32'h3132_3334, 32, 0));
      set_cfg(0, 2'd3, 1, 0, 0, 0, 2'b10);
      wr(32'h2CCC_4C8C);
      check("R5 mirror after reorder", crc_raw, ref_step(32'hFFFF_FFFF, 32'h3132_3334, 32, 0));
      set_cfg(1, 0, 1, 0, 0, 0, 2'b10);
      wr(32'h0000_009C);
      check("R5 byte mirror", crc_raw, ref_step(32'hFFFF_FFFF, 32'h39, 8, 0));
   endtask

   task automatic t_byte_ignore();
      set_cfg(1, 2'd3, 0, 0, 0, 0, 2'b10);
      wr(32'hABCD_EF39);
      check("R3 upper bits ignored", crc_raw, ref_step(32'hFFFF_FFFF, 32'h39, 8, 0));
   endtask

   task automatic t_seed();
      set_cfg(0, 0, 0, 0, 0, 0, 2'b00);
      cycle(1, 32'hDEAD_BEEF, 0, 2'b00, 0, 0);
      check("R7 seed load", crc_raw, 32'hDEAD_BEEF);
      set_cfg(0, 0, 0, 0, 0, 0, 2'b00);
      check("R6 init keep", crc_raw, 32'hDEAD_BEEF);
      wr(32'h0102_0304);
      check("R7 resume from seed", crc_raw, ref_step(32'hDEAD_BEEF, 32'h0102_0304, 32, 0));
   endtask

   task automatic t_priority();
      cycle(1, 32'h1357_9BDF, 0, 2'b00, 1, 32'hFFFF_0000);
      check("R8 seed over data", crc_raw, 32'h1357_9BDF);
      cycle(0, 0, 1, 2'b01, 1, 32'h1234_5678);
      check("R8 init over data", crc_raw, 32'h0);
      cycle(1, 32'h2468_ACE0, 1, 2'b10, 0, 0);
      check("R8 seed over init", crc_raw, 32'h2468_ACE0);
   endtask

   task automatic t_cfg_timing();
      set_cfg(0, 0, 0, 0, 0, 0, 2'b10);
      cfg_byte_mode = 1;
      cycle(0, 0, 1, 2'b00, 1, 32'h3132_3334);
      check("R10 old cfg used", crc_raw, ref_step(32'hFFFF_FFFF, 32'h3132_3334, 32, 0));
      wr(32'h0000_0035);
      check("R10 new cfg next", crc_raw,
            ref_step(ref_step(32'hFFFF_FFFF, 32'h3132_3334, 32, 0), 32'h35, 8, 0));
   endtask

   task automatic t_post();
      set_cfg(0, 0, 0, 0, 1, 0, 2'b00);
      cycle(1, 32'h1234_5678, 0, 2'b00, 0, 0);
      check("R9 wide mirror", crc_post, 32'h1E6A_2C48);
      set_cfg(0, 0, 0, 0, 0, 1, 2'b00);
      check("R9 wide invert", crc_post, 32'hEDCB_A987);
      set_cfg(0, 0, 0, 0, 1, 1, 2'b00);
      check("R9 wide both", crc_post, 32'hE195_D3B7);
      set_cfg(0, 0, 0, 1, 1, 1, 2'b00);
      cycle(1, 32'hFFFF_ABCD, 0, 2'b00, 0, 0);
      check("R7 narrow seed zext", crc_raw, 32'h0000_ABCD);
      check("R9 narrow both", crc_post, 32'h0000_4C2A);
      set_cfg(0, 0, 0, 1, 0, 1, 2'b00);
      check("R9 narrow invert", crc_post, 32'h0000_5432);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_crc32_string();
      t_crc16_string();
      t_orders();
      t_bitrev();
      t_byte_ignore();
      t_seed();
      t_priority();
      t_cfg_timing();
      t_post();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule